// File: doc/BRIEF.md
# Half-Step SPI Serial Clock Generator

This block derives the serial clock of an SPI host port from a fixed 125 MHz source. Its clock input `clk` runs at twice the source rate, so one `clk` cycle is one half-cycle of the source. Each output period can therefore span an odd number of source half-cycles, which gives divide ratios of N and N+0.5. An optional divide-by-8 prescale stage slows every ratio for low-frequency operation.

Reads and writes each have their own divider field and their own half-step enable. The `dir_wr` input chooses which pair drives the clock. A polarity control sets the idle level of the serial clock and its inverse as the active level. Two one-cycle strobes mark the leading edge (into the active level) and the trailing edge of every output period, so the shift logic can launch and capture data on the `clk` domain.

Top module: `spi_halfstep_clkgen`

## Requirements
- R1: With half-step off and prescale off, a divider value N (1..7) gives an active phase of N clk cycles and an idle-level phase of N clk cycles, so the frequency is 125 MHz / N.
- R2: With half-step on, the active phase lasts N+1 clk cycles and the idle-level phase lasts N clk cycles, a ratio of N+0.5 (for example N=2 gives 50 MHz).
- R3: With `low_freq` set, both phase lengths are multiplied by 8 (N=1 gives 15.625 MHz; N=1 with half-step gives about 10.42 MHz).
- R4: `dir_wr`=1 selects `wr_div`/`wr_half`, and `dir_wr`=0 selects `rd_div`/`rd_half`. The fields that are not selected have no effect on the output.
- R5: A divider value of 0 behaves exactly like 1.
- R6: The selected divider, half-step and prescale settings are sampled only at the leading edge of a period. A change made mid-period leaves the current period unchanged and applies from the next leading edge.
- R7: While `run` is low, no strobe is issued, the period counter restarts, and `sclk` settles one cycle later to the value of `clk_inv`. `clk_inv` is taken only while `run` is low.
- R8: The cycle after `run` is first sampled high, `sclk` shows the active level (the inverse of the idle level), and `lead_stb` is high.
- R9: `lead_stb` is high for exactly the cycles in which `sclk` has just moved to the active level. `trail_stb` is high for exactly the cycles in which it has just moved to the idle level. The two are never high together.
- R10: After a synchronous reset, `sclk`, `lead_stb` and `trail_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the source rate (one source half-cycle) |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Clock generation enable |
| dir_wr | input | 1 | 1 selects the write settings, 0 selects the read settings |
| rd_div | input | 3 | Read integer divider (0 treated as 1) |
| rd_half | input | 1 | Read half-step enable |
| wr_div | input | 3 | Write integer divider (0 treated as 1) |
| wr_half | input | 1 | Write half-step enable |
| low_freq | input | 1 | Enable the divide-by-8 prescale stage |
| clk_inv | input | 1 | Idle level of `sclk` (1 = inverted polarity) |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | Strobe on the edge into the active level |
| trail_stb | output | 1 | Strobe on the edge into the idle level |

## Verification
Random settings of both field pairs, the direction, the prescale and the polarity are each compared against expected phase lengths, over two full periods per setting. Matching both phase lengths separates integer from half-step timing, and each factor of 8 shows the prescale is present. Because the unselected pair is always randomized differently, a swapped direction select shows up as wrong lengths. Directed cases cover a divider of 0, the longest ratio (7.5 with prescale), the shortest ratio (1), and a setting change made in the middle of a period, which must leave that period intact.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int HSC_DIV_W = 3;

  typedef struct packed {
    logic [HSC_DIV_W-1:0] div;
    logic                 half;
    logic                 low;
  } hsc_cfg_t;
endpackage

// File: rtl/hsc_select.sv
module hsc_select
  import hsc_pkg::*;
(
  input  logic                 dir_wr,
  input  logic [HSC_DIV_W-1:0] rd_div,
  input  logic                 rd_half,
  input  logic [HSC_DIV_W-1:0] wr_div,
  input  logic                 wr_half,
  input  logic                 low_freq,
  output hsc_cfg_t             cfg
);
  logic [HSC_DIV_W-1:0] raw_div;

  always_comb begin
    raw_div  = dir_wr ? wr_div : rd_div;
    cfg.half = dir_wr ? wr_half : rd_half;
    cfg.low  = low_freq;
    // a zero divider is promoted to one
    cfg.div  = (raw_div == '0) ? HSC_DIV_W'(1) : raw_div;
  end
endmodule

// File: rtl/hsc_ratio.sv
module hsc_ratio
  import hsc_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int CNT_W    = 7
) (
  input  hsc_cfg_t         cfg,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] period_len
);
  logic [CNT_W-1:0] base_hi;
  logic [CNT_W-1:0] base_per;

  always_comb begin
    // lengths counted in source half-cycles
    base_hi  = CNT_W'(cfg.div) + CNT_W'(cfg.half);
    base_per = CNT_W'(cfg.div) + base_hi;
    if (cfg.low) begin
      high_len   = CNT_W'(int'(base_hi) * PRESCALE);
      period_len = CNT_W'(int'(base_per) * PRESCALE);
    end else begin
      high_len   = base_hi;
      period_len = base_per;
    end
  end
endmodule

// File: rtl/hsc_phase_gen.sv
module hsc_phase_gen
  import hsc_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int CNT_W    = 7
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     clk_inv,
  input  hsc_cfg_t new_cfg,
  output logic     sclk,
  output logic     lead_stb,
  output logic     trail_stb
);
  hsc_cfg_t         act_cfg;
  logic             inv_q;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_high;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] cnt_nxt;

  hsc_ratio #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_ratio (
    .cfg       (act_cfg),
    .high_len  (act_high),
    .period_len(act_period)
  );

  assign cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg   <= '0;
      inv_q     <= 1'b0;
      running   <= 1'b0;
      cnt       <= '0;
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
      if (!run) begin
        running <= 1'b0;
        cnt     <= '0;
        inv_q   <= clk_inv;
        sclk    <= clk_inv;
        act_cfg <= new_cfg;
      end else if (!running || cnt_nxt == act_period) begin
        // period boundary: adopt new settings, drive active level
        running  <= 1'b1;
        cnt      <= '0;
        act_cfg  <= new_cfg;
        sclk     <= ~inv_q;
        lead_stb <= 1'b1;
      end else begin
        cnt <= cnt_nxt;
        if (cnt_nxt == act_high) begin
          sclk      <= inv_q;
          trail_stb <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_halfstep_clkgen.sv
module spi_halfstep_clkgen
  import hsc_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int DIV_W    = HSC_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             dir_wr,
  input  logic [DIV_W-1:0] rd_div,
  input  logic             rd_half,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_half,
  input  logic             low_freq,
  input  logic             clk_inv,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam int PER_MAX = (2 * DIV_MAX + 1) * PRESCALE;
  localparam int CNT_W   = $clog2(PER_MAX + 1);

  hsc_cfg_t sel_cfg;

  hsc_select u_sel (
    .dir_wr  (dir_wr),
    .rd_div  (HSC_DIV_W'(rd_div)),
    .rd_half (rd_half),
    .wr_div  (HSC_DIV_W'(wr_div)),
    .wr_half (wr_half),
    .low_freq(low_freq),
    .cfg     (sel_cfg)
  );

  hsc_phase_gen #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .clk_inv  (clk_inv),
    .new_cfg  (sel_cfg),
    .sclk     (sclk),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb)
  );
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(lead_stb && trail_stb));

  assert_lead_edge_R9: assert property (@(posedge clk) disable iff (rst)
    lead_stb |-> (sclk != $past(sclk)));

  assert_trail_edge_R9: assert property (@(posedge clk) disable iff (rst)
    trail_stb |-> (sclk != $past(sclk)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!lead_stb && !trail_stb));

  assert_run_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> lead_stb);

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (!sclk && !lead_stb && !trail_stb));
endmodule

bind spi_halfstep_clkgen hsc_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .sclk     (sclk),
  .lead_stb (lead_stb),
  .trail_stb(trail_stb)
);

// File: tb/tb_spi_halfstep_clkgen.sv
module tb_spi_halfstep_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       dir_wr = 1'b0;
  logic [2:0] rd_div = 3'd1;
  logic       rd_half = 1'b0;
  logic [2:0] wr_div = 3'd1;
  logic       wr_half = 1'b0;
  logic       low_freq = 1'b0;
  logic       clk_inv = 1'b0;
  logic       sclk, lead_stb, trail_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spi_halfstep_clkgen dut (
    .clk(clk), .rst(rst), .run(run), .dir_wr(dir_wr),
    .rd_div(rd_div), .rd_half(rd_half), .wr_div(wr_div), .wr_half(wr_half),
    .low_freq(low_freq), .clk_inv(clk_inv),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic int exp_hi(logic [2:0] d, logic h, logic lf);
    int n = (d == 0) ? 1 : int'(d);
    return (n + int'(h)) * (lf ? 8 : 1);
  endfunction

  function automatic int exp_lo(logic [2:0] d, logic lf);
    int n = (d == 0) ? 1 : int'(d);
    return n * (lf ? 8 : 1);
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_lead();
    do @(negedge clk); while (!lead_stb);
  endtask

  // counts from a seen lead strobe to the trail strobe and on to the next lead
  task automatic phases(output int hi, output int lo);
    hi = 0; lo = 0;
    do begin @(negedge clk); hi++; end while (!trail_stb);
    do begin @(negedge clk); lo++; end while (!lead_stb);
  endtask

  task automatic run_case(string tag, logic dw, logic [2:0] rdv, logic rdh,
                          logic [2:0] wrv, logic wrh, logic lf, logic inv);
    int hi, lo;
    logic [2:0] d;
    logic h;
    @(negedge clk);
    run = 1'b0; dir_wr = dw; rd_div = rdv; rd_half = rdh;
    wr_div = wrv; wr_half = wrh; low_freq = lf; clk_inv = inv;
    @(negedge clk); @(negedge clk);
    check({tag, " R7 idle level"}, int'(sclk), int'(inv));
    check({tag, " R7 no strobe idle"}, int'(lead_stb | trail_stb), 0);
    run = 1'b1;
    @(negedge clk);
    check({tag, " R8 lead on start"}, int'(lead_stb), 1);
    check({tag, " R8 active level"}, int'(sclk), int'(!inv));
    d = dw ? wrv : rdv;
    h = dw ? wrh : rdh;
    for (int p = 0; p < 2; p++) begin
      phases(hi, lo);
      check({tag, " R1 R2 R3 R4 R5 active len"}, hi, exp_hi(d, h, lf));
      check({tag, " R1 R2 R3 R4 R5 idle len"}, lo, exp_lo(d, lf));
      check({tag, " R9 lead level"}, int'(sclk), int'(!inv));
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int hi, lo;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check("R10 sclk", int'(sclk), 0);
    check("R10 strobes", int'(lead_stb | trail_stb), 0);
    rst = 1'b0;

    // directed corners
    run_case("int1",   1'b0, 3'd1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0);
    run_case("half2",  1'b0, 3'd2, 1'b1, 3'd7, 1'b0, 1'b0, 1'b1);
    run_case("half3w", 1'b1, 3'd6, 1'b0, 3'd3, 1'b1, 1'b0, 1'b1);
    run_case("zero",   1'b0, 3'd0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0);
    run_case("zeroh",  1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
    run_case("lowh1",  1'b0, 3'd1, 1'b1, 3'd2, 1'b0, 1'b1, 1'b1);
    run_case("max",    1'b1, 3'd1, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0);

    // R6: change settings mid-period
    run_case("pre6", 1'b0, 3'd3, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0);
    wait_lead();
    rd_div = 3'd2; rd_half = 1'b1;
    phases(hi, lo);
    check("R6 current active len kept", hi, 3);
    check("R6 current idle len kept", lo, 3);
    phases(hi, lo);
    check("R6 next active len new", hi, 3);
    check("R6 next idle len new", lo, 2);

    // random mix
    for (int i = 0; i < 30; i++) begin
      run_case("rand", 1'($urandom), 3'($urandom), 1'($urandom),
               3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 final no strobe", int'(lead_stb | trail_stb), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule